// File: doc/BRIEF.md
# Shift-and-Add Output Accumulator

This block is the result stage behind an array of multiply-accumulate cells. Every cell presents a running sum of fixed width on a flat bus. A cell address chooses one of those sums each clock. A mode input then decides what the stage's own register captures. It either takes the chosen sum as it is, or adds the chosen sum to its current contents after moving those contents eight bit positions toward the least significant end.

Chaining the add mode across several clocks combines partial products that were formed from byte-wide operands. Each earlier partial product is weighted one byte lower than the newest one. This builds results with wider coefficients or wider data than the cells handle natively.

The stored value drives the result port through two independent gates, one for the low field and one for the high field. A gated-off field reads as zero. The shift can copy the sign bit or fill with zeros. A parameter picks which, and it is fixed when the block is built.

Top module: `sa_output_stage`

## Requirements
- R1: A synchronous active-high `rst` clears the register. With both enables high, `sum_out` reads zero at the first sample after a reset edge.
- R2: With `shift_add` low, the register captures the addressed cell sum exactly at the next rising edge.
- R3: Address value k selects cell k, which sits at bits [26k+25 : 26k] of `cell_sums`. All eight addresses reach their own cell.
- R4: With `shift_add` high and `SIGNED_SHIFT`=1, the next value is the addressed cell sum plus the stored value shifted right by 8, with the sign bit copied into the vacated top 8 bits.
- R5: With `shift_add` high and `SIGNED_SHIFT`=0, the vacated top 8 bits of the shifted value are zero.
- R6: The add is modulo 2^26. A carry out of bit 25 is dropped.
- R7: When `lo_en` is low, `sum_out[15:0]` reads zero. When it is high, those bits show the stored value.
- R8: When `hi_en` is low, `sum_out[25:16]` reads zero. When it is high, those bits show the stored value. Neither enable changes the stored value.
- R9: The register updates on every rising edge, so a new address or mode given on each successive clock yields a new result each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_sums | input | 208 | Eight 26-bit cell sums, cell k at bits 26k upward |
| cell_sel | input | 3 | Address of the cell sum to use |
| shift_add | input | 1 | 1: add to shifted register; 0: plain load |
| lo_en | input | 1 | Enable for result bits 15:0 |
| hi_en | input | 1 | Enable for result bits 25:16 |
| sum_out | output | 26 | Gated stored value |

## Verification
Every cell is given a distinct value and the addresses are walked one per clock. This separates a wrong or stuck address decode from a missed update. A stored value with its top bit set is then combined in add mode. Two builds run side by side, one filling with the sign and one with zeros, so the two fill rules give different answers from the same stimulus. Multi-pass chains and a near-full-scale sum expose wrong shift distance and overflow handling. Toggling each enable around an add step shows that the gates mask only their own field and leave the stored value untouched.

// File: rtl/sa_output_pkg.sv
package sa_output_pkg;
   typedef enum logic {
      MODE_LOAD  = 1'b0,
      MODE_SHADD = 1'b1
   } sa_mode_e;

   localparam int unsigned DEF_CELLS = 8;
   localparam int unsigned DEF_WIDTH = 26;
   localparam int unsigned DEF_SHIFT = 8;
   localparam int unsigned DEF_LO_W  = 16;
endpackage

// File: rtl/sa_cell_select.sv
module sa_cell_select #(
   parameter int unsigned NUM_CELLS = 8,
   parameter int unsigned SUM_W     = 26,
   localparam int unsigned SEL_W    = $clog2(NUM_CELLS)
) (
   input  logic [NUM_CELLS*SUM_W-1:0] cells,
   input  logic [SEL_W-1:0]           sel,
   output logic [SUM_W-1:0]           picked
);
   logic [SUM_W-1:0] lane [NUM_CELLS];

   for (genvar g = 0; g < NUM_CELLS; g++) begin : g_lane
      assign lane[g] = cells[g*SUM_W +: SUM_W];
   end

   assign picked = lane[sel];
endmodule

// File: rtl/sa_shift_unit.sv
module sa_shift_unit #(
   parameter int unsigned SUM_W        = 26,
   parameter int unsigned SHIFT_AMT    = 8,
   parameter bit          SIGNED_SHIFT = 1'b1
) (
   input  logic [SUM_W-1:0] din,
   output logic [SUM_W-1:0] dout
);
   localparam int unsigned KEEP_W = SUM_W - SHIFT_AMT;

   if (SIGNED_SHIFT) begin : g_arith
      assign dout = {{SHIFT_AMT{din[SUM_W-1]}}, din[SUM_W-1:SHIFT_AMT]};

      // R4: vacated bits plus the kept top bit all equal the input sign
      always_comb begin
         p_sign_fill_r4: assert ($countones(dout[SUM_W-1 -: SHIFT_AMT+1]) == 0 ||
                                 $countones(dout[SUM_W-1 -: SHIFT_AMT+1]) == SHIFT_AMT+1)
            else $error("sign fill broken");
      end
   end else begin : g_logic
      assign dout = {{SHIFT_AMT{1'b0}}, din[SUM_W-1:SHIFT_AMT]};

      // R5: vacated bits are zero
      always_comb begin
         p_zero_fill_r5: assert ($countones(dout[SUM_W-1 -: SHIFT_AMT]) == 0)
            else $error("zero fill broken");
      end
   end

   always_comb begin
      p_kept_bits_r4: assert (dout[KEEP_W-1:0] == din[SUM_W-1:SHIFT_AMT])
         else $error("shift distance wrong");
   end
endmodule

// File: rtl/sa_out_gate.sv
module sa_out_gate #(
   parameter int unsigned SUM_W = 26,
   parameter int unsigned LO_W  = 16,
   localparam int unsigned HI_W = SUM_W - LO_W
) (
   input  logic [SUM_W-1:0] din,
   input  logic             lo_en,
   input  logic             hi_en,
   output logic [SUM_W-1:0] dout
);
   logic [LO_W-1:0] lo_part;
   logic [HI_W-1:0] hi_part;

   assign lo_part = lo_en ? din[LO_W-1:0]     : '0;
   assign hi_part = hi_en ? din[SUM_W-1:LO_W] : '0;
   assign dout    = {hi_part, lo_part};

   always_comb begin
      if (!lo_en) begin
         p_lo_masked_r7: assert (dout[LO_W-1:0] == '0) else $error("low field leaks");
      end
      if (!hi_en) begin
         p_hi_masked_r8: assert (dout[SUM_W-1:LO_W] == '0) else $error("high field leaks");
      end
   end
endmodule

// File: rtl/sa_output_stage.sv
module sa_output_stage
   import sa_output_pkg::*;
#(
   parameter int unsigned NUM_CELLS    = DEF_CELLS,
   parameter int unsigned SUM_W        = DEF_WIDTH,
   parameter int unsigned SHIFT_AMT    = DEF_SHIFT,
   parameter int unsigned LO_W         = DEF_LO_W,
   parameter bit          SIGNED_SHIFT = 1'b1,
   localparam int unsigned SEL_W       = $clog2(NUM_CELLS)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_CELLS*SUM_W-1:0] cell_sums,
   input  logic [SEL_W-1:0]           cell_sel,
   input  logic                       shift_add,
   input  logic                       lo_en,
   input  logic                       hi_en,
   output logic [SUM_W-1:0]           sum_out
);
   initial begin
      if (NUM_CELLS < 2 || (1 << SEL_W) != NUM_CELLS)
         $fatal(1, "NUM_CELLS must be a power of two, at least 2");
      if (SHIFT_AMT == 0 || SHIFT_AMT >= SUM_W)
         $fatal(1, "SHIFT_AMT must lie in 1..SUM_W-1");
      if (LO_W == 0 || LO_W >= SUM_W)
         $fatal(1, "LO_W must lie in 1..SUM_W-1");
   end

   sa_mode_e         mode;
   logic [SUM_W-1:0] picked;
   logic [SUM_W-1:0] shifted;
   logic [SUM_W-1:0] acc_q;
   logic [SUM_W-1:0] acc_d;

   assign mode = shift_add ? MODE_SHADD : MODE_LOAD;

   sa_cell_select #(.NUM_CELLS(NUM_CELLS), .SUM_W(SUM_W)) u_select (
      .cells (cell_sums),
      .sel   (cell_sel),
      .picked(picked)
   );

   sa_shift_unit #(.SUM_W(SUM_W), .SHIFT_AMT(SHIFT_AMT), .SIGNED_SHIFT(SIGNED_SHIFT)) u_shift (
      .din (acc_q),
      .dout(shifted)
   );

   always_comb begin
      unique case (mode)
         MODE_SHADD: acc_d = picked + shifted;
         default:    acc_d = picked;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_d;
   end

   sa_out_gate #(.SUM_W(SUM_W), .LO_W(LO_W)) u_gate (
      .din  (acc_q),
      .lo_en(lo_en),
      .hi_en(hi_en),
      .dout (sum_out)
   );

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> acc_q == '0)
      else $error("register not cleared by reset");

   p_plain_load_r2: assert property (@(posedge clk) disable iff (rst)
      !shift_add |=> acc_q == $past(picked))
      else $error("plain load missed the addressed sum");

   p_zero_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (shift_add && picked == '0 && acc_q == '0) |=> acc_q == '0)
      else $error("zero accumulate drifted");

   p_every_edge_r9: assert property (@(posedge clk) disable iff (rst)
      (!shift_add && picked != acc_q) |=> !$stable(acc_q))
      else $error("register skipped an edge");
endmodule

// File: tb/sa_output_stage_tb.sv
module sa_output_stage_tb;
   localparam int W = 26;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] cv [N];
   logic [N*W-1:0] bus;
   logic [2:0]   cell_sel = '0;
   logic         shift_add = 1'b0;
   logic         lo_en = 1'b1;
   logic         hi_en = 1'b1;
   logic [W-1:0] out_s, out_l;
   logic [W-1:0] exp_s, exp_l;
   int           n_chk = 0;
   int           n_err = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int k = 0; k < N; k++) bus[k*W +: W] = cv[k];
   end

   sa_output_stage u_dut (
      .clk(clk), .rst(rst), .cell_sums(bus), .cell_sel(cell_sel),
      .shift_add(shift_add), .lo_en(lo_en), .hi_en(hi_en), .sum_out(out_s)
   );

   sa_output_stage #(.SIGNED_SHIFT(1'b0)) u_dut_lg (
      .clk(clk), .rst(rst), .cell_sums(bus), .cell_sel(cell_sel),
      .shift_add(shift_add), .lo_en(lo_en), .hi_en(hi_en), .sum_out(out_l)
   );

   function automatic logic [W-1:0] nxt(input logic [W-1:0] prev, input logic [W-1:0] c,
                                        input bit sa, input bit sgn);
      logic [W-1:0] s;
      s = sgn ? W'($signed(prev) >>> 8) : (prev >> 8);
      return sa ? W'(c + s) : c;
   endfunction

   function automatic logic [W-1:0] gate(input logic [W-1:0] v);
      return v & {(hi_en ? 10'h3FF : 10'h000), (lo_en ? 16'hFFFF : 16'h0000)};
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic step(input int sel, input bit sa);
      cell_sel  = 3'(sel);
      shift_add = sa;
      @(posedge clk);
      if (rst) begin
         exp_s = '0; exp_l = '0;
      end else begin
         exp_s = nxt(exp_s, cv[sel], sa, 1'b1);
         exp_l = nxt(exp_l, cv[sel], sa, 1'b0);
      end
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      step(0, 1'b0);
      chk("R1 reset signed", out_s, '0);
      chk("R1 reset logical", out_l, '0);
      rst = 1'b0;
   endtask

   task automatic t_select_each;
      for (int k = 0; k < N; k++) cv[k] = W'(32'h0ABC00 + k * 32'h111111 + k);
      for (int k = 0; k < N; k++) begin
         step(k, 1'b0);
         chk($sformatf("R2 R3 R9 load cell %0d", k), out_s, cv[k]);
         chk($sformatf("R2 R3 load cell %0d logical", k), out_l, cv[k]);
      end
   endtask

   task automatic t_sign_fill;
      cv[3] = 26'h3FFFF00;
      cv[4] = 26'h0000005;
      step(3, 1'b0);
      step(4, 1'b1);
      chk("R4 arithmetic shift-add", out_s, 26'h0000004);
      chk("R5 logical shift-add", out_l, 26'h0040004);
   endtask

   task automatic t_chain;
      cv[0] = 26'h0000012;
      cv[1] = 26'h0003456;
      cv[2] = 26'h3F80000;
      step(0, 1'b0);
      step(1, 1'b1);
      chk("R4 chain pass 2", out_s, 26'h0003456);
      step(2, 1'b1);
      chk("R4 chain pass 3 signed", out_s, exp_s);
      chk("R5 chain pass 3 logical", out_l, exp_l);
      step(1, 1'b1);
      chk("R4 chain pass 4 signed", out_s, exp_s);
      chk("R5 chain pass 4 logical", out_l, exp_l);
   endtask

   task automatic t_wrap;
      cv[5] = 26'h1FFFFFF;
      cv[6] = 26'h3FFFFFF;
      step(5, 1'b0);
      step(6, 1'b1);
      chk("R6 modulo add", out_s, 26'h001FFFE);
      chk("R6 modulo add logical", out_l, 26'h001FFFE);
   endtask

   task automatic t_enables;
      cv[7] = 26'h2ABCDEF;
      step(7, 1'b0);
      lo_en = 1'b0; #1;
      chk("R7 low field masked", out_s, 26'h2AB0000);
      lo_en = 1'b1; hi_en = 1'b0; #1;
      chk("R8 high field masked", out_s, 26'h000CDEF);
      lo_en = 1'b0; #1;
      chk("R7 R8 both masked", out_s, '0);
      step(7, 1'b1);
      chk("R7 masked during add", out_s, '0);
      lo_en = 1'b1; hi_en = 1'b1; #1;
      chk("R8 register untouched by enables", out_s, exp_s);
      chk("R8 untouched logical", out_l, gate(exp_l));
   endtask

   task automatic t_midreset;
      step(7, 1'b0);
      rst = 1'b1;
      step(7, 1'b0);
      chk("R1 mid-run reset", out_s, '0);
      rst = 1'b0;
      step(7, 1'b0);
      chk("R1 R2 load after reset", out_s, cv[7]);
   endtask

   initial begin
      for (int k = 0; k < N; k++) cv[k] = '0;
      exp_s = '0; exp_l = '0;
      @(negedge clk);
      t_reset;
      t_select_each;
      t_sign_fill;
      t_chain;
      t_wrap;
      t_enables;
      t_midreset;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule